// File: doc/BRIEF.md
# Configurable-Frame Serial Transmitter

This block turns bytes taken from a transmit queue into asynchronous serial frames on a single output line. Timing comes from a clock-enable input that pulses at eight times the baud rate, so every bit on the line lasts eight of those pulses. The frame shape is read from control inputs each time a frame starts. The data length can be five to eight bits, there can be one or two stop bits, and parity can be none, odd, even, forced high or forced low.

The queue sits outside the block and shows its head entry on `q_data`. The block pops that entry with a one-cycle `q_pop` pulse at the moment a frame begins. Optional hardware flow control holds off new frames while the clear-to-send input is low. A frame that is already on the line is not affected by it. Two outputs report progress: `busy` covers the whole frame, and `frame_done` marks its end. The port enable gates the whole block.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is high, `busy` is low, and `q_pop` and `frame_done` are low.
- R2: A frame sends a low start bit, then the data bits with the least significant bit first. `len_sel` values 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits.
- R3: After the data bits and any parity bit come high stop bits: two when `stop2` is 1, one when it is 0.
- R4: `par_sel` 4 gives odd parity (the data bits plus the parity bit hold an odd number of ones). 6 gives even parity. 5 sends a constant 1 and 7 sends a constant 0. Values 0 to 3 send no parity bit.
- R5: Every bit of a frame, including the start bit, stays on `txd` for exactly `OVS` (default 8) pulses of `tick`.
- R6: When the block is idle, `port_en` is high, the queue is not empty and flow control allows it, `q_pop` pulses for one cycle. In the next cycle `busy` is high and the start bit is on the line.
- R7: With `flow_en` high, no frame starts while `cts` is low. With `flow_en` low, `cts` has no effect.
- R8: `cts` is looked at only when a frame starts. If it falls during a frame, that frame still completes unchanged.
- R9: `frame_done` is high for one cycle, in the cycle whose `tick` ends the last stop bit. `busy` is low in the following cycle.
- R10: While `port_en` is low, nothing is popped and `txd` stays high. Dropping `port_en` during a frame abandons it at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Clock enable at OVS times the baud rate |
| port_en | input | 1 | Port enable |
| len_sel | input | 2 | Data length code (5 + value bits) |
| stop2 | input | 1 | Two stop bits when set |
| par_sel | input | 3 | Parity mode code |
| flow_en | input | 1 | Hardware flow control enable |
| cts | input | 1 | Clear to send, active high |
| q_empty | input | 1 | Transmit queue is empty |
| q_data | input | 8 | Head entry of the transmit queue |
| q_pop | output | 1 | Pop strobe for the queue head |
| txd | output | 1 | Serial output, idles high |
| busy | output | 1 | A frame is in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the block with its default oversampling of eight and drives `tick` once every third clock. This makes each bit span 24 clocks, so every bit can be sampled at its middle, after four ticks. The directed frames cover every length code, both stop settings, all four active parity modes and one of the unused parity codes. With them, the shortest frame (7 bits) and the longest frame (12 bits) are both sent. Flow control is exercised with `cts` low before a frame, with `cts` falling during a frame, and with flow control turned off. The enable is exercised both while idle and in the middle of a frame.

// File: rtl/uart_frame_tx_pkg.sv
package uart_frame_tx_pkg;

  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FRAME_W = 1 + DATA_W + 1 + 2;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_ODD   = 3'd4,
    PAR_HIGH  = 3'd5,
    PAR_EVEN  = 3'd6,
    PAR_LOW   = 3'd7
  } par_mode_e;

  // number of data bits selected by the 2-bit length code
  function automatic logic [CNT_W-1:0] data_len(input logic [1:0] code);
    return CNT_W'(5) + CNT_W'(code);
  endfunction

  // codes 0..3 carry no parity bit
  function automatic logic par_on(input logic [2:0] code);
    return code[2];
  endfunction

  function automatic logic par_value(input logic [2:0] code,
                                     input logic [DATA_W-1:0] data,
                                     input logic [1:0] len);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (CNT_W'(i) < data_len(len)) acc = acc ^ data[i];
    case (code)
      PAR_ODD:  return ~acc;
      PAR_EVEN: return acc;
      PAR_HIGH: return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/uart_frame_tx_timer.sv
module uart_frame_tx_timer #(
  parameter int unsigned OVS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  input  logic tick,
  output logic bit_end
);
  localparam int unsigned TW = (OVS > 1) ? $clog2(OVS) : 1;

  logic [TW-1:0] cnt;

  assign bit_end = run && !clr && tick && (cnt == TW'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clr || !run)     cnt <= '0;
    else if (bit_end)         cnt <= '0;
    else if (tick)            cnt <= cnt + TW'(1);
  end
endmodule

// File: rtl/uart_frame_tx_builder.sv
module uart_frame_tx_builder
  import uart_frame_tx_pkg::*;
(
  input  logic [DATA_W-1:0]  data,
  input  logic [1:0]         len_sel,
  input  logic               stop2,
  input  logic [2:0]         par_sel,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);
  logic [CNT_W-1:0] n;
  logic [CNT_W-1:0] pidx;

  always_comb begin
    n     = data_len(len_sel);
    pidx  = n + CNT_W'(1);
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (CNT_W'(i) < n) frame[i+1] = data[i];
    if (par_on(par_sel)) frame[pidx] = par_value(par_sel, data, len_sel);
    nbits = CNT_W'(2) + n + CNT_W'(par_on(par_sel)) + CNT_W'(stop2);
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_frame_tx_pkg::*;
#(
  parameter int unsigned OVS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              port_en,
  input  logic [1:0]        len_sel,
  input  logic              stop2,
  input  logic [2:0]        par_sel,
  input  logic              flow_en,
  input  logic              cts,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] q_data,
  output logic              q_pop,
  output logic              txd,
  output logic              busy,
  output logic              frame_done
);
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   left;
  logic [FRAME_W-1:0] new_frame;
  logic [CNT_W-1:0]   new_bits;
  logic               frame_start;
  logic               bit_end;
  logic               flow_ok;

  assign flow_ok     = !flow_en || cts;
  assign frame_start = !busy && port_en && !q_empty && flow_ok;
  assign q_pop       = frame_start;

  uart_frame_tx_builder u_build (
    .data    (q_data),
    .len_sel (len_sel),
    .stop2   (stop2),
    .par_sel (par_sel),
    .frame   (new_frame),
    .nbits   (new_bits)
  );

  uart_frame_tx_timer #(.OVS(OVS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .clr     (frame_start),
    .tick    (tick),
    .bit_end (bit_end)
  );

  assign frame_done = port_en && busy && bit_end && (left == CNT_W'(1));
  assign txd        = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      left  <= '0;
    end else if (!port_en) begin
      busy  <= 1'b0;
      shreg <= '1;
      left  <= '0;
    end else if (frame_start) begin
      busy  <= 1'b1;
      shreg <= new_frame;
      left  <= new_bits;
    end else if (busy && bit_end) begin
      shreg <= {1'b1, shreg[FRAME_W-1:1]};
      left  <= left - CNT_W'(1);
      if (left == CNT_W'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic port_en,
  input logic flow_en,
  input logic cts,
  input logic q_empty,
  input logic q_pop,
  input logic txd,
  input logic busy,
  input logic frame_done,
  input logic bit_end
);
  // R1
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  // R6
  pop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |-> (port_en && !q_empty && !busy));
  // R6
  pop_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |=> (busy && !txd));
  // R7
  flow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && !cts) |-> !q_pop);
  // R9
  done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy);
  // R9
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (busy && bit_end));
  // R10
  dis_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!busy && txd));
  // R10
  dis_nopop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> !q_pop);
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .port_en    (port_en),
  .flow_en    (flow_en),
  .cts        (cts),
  .q_empty    (q_empty),
  .q_pop      (q_pop),
  .txd        (txd),
  .busy       (busy),
  .frame_done (frame_done),
  .bit_end    (bit_end)
);

// File: tb/sim_uart_frame_tx.sv
module sim_uart_frame_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       port_en = 1'b0;
  logic [1:0] len_sel = 2'd3;
  logic       stop2 = 1'b0;
  logic [2:0] par_sel = 3'd0;
  logic       flow_en = 1'b0;
  logic       cts = 1'b0;
  logic       q_empty = 1'b1;
  logic [7:0] q_data = 8'h00;
  logic       q_pop, txd, busy, frame_done;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;
  logic [1:0] tdiv = 2'd0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= (tdiv == 2'd2) ? 2'd0 : tdiv + 2'd1;
    tick <= (tdiv == 2'd1);
  end

  uart_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .port_en(port_en),
    .len_sel(len_sel), .stop2(stop2), .par_sel(par_sel),
    .flow_en(flow_en), .cts(cts), .q_empty(q_empty), .q_data(q_data),
    .q_pop(q_pop), .txd(txd), .busy(busy), .frame_done(frame_done)
  );

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the tick was consumed
  task automatic wait_tick();
    while (!tick) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // sends one frame and checks every bit at its middle
  task automatic run_frame(input string req, input logic [7:0] d,
                           input logic [1:0] ls, input logic s2,
                           input logic [2:0] ps, input bit drop_cts);
    logic exp_bits [12];
    int   n, nb, ones;
    n = 5 + int'(ls);
    ones = 0;
    for (int i = 0; i < 12; i++) exp_bits[i] = 1'b1;
    exp_bits[0] = 1'b0;
    for (int i = 0; i < n; i++) begin
      exp_bits[1+i] = d[i];
      if (d[i]) ones++;
    end
    nb = 1 + n;
    if (ps == 3'd4) begin exp_bits[nb] = (ones % 2 == 0); nb++; end
    else if (ps == 3'd6) begin exp_bits[nb] = (ones % 2 == 1); nb++; end
    else if (ps == 3'd5) begin exp_bits[nb] = 1'b1; nb++; end
    else if (ps == 3'd7) begin exp_bits[nb] = 1'b0; nb++; end
    nb += s2 ? 2 : 1;
    @(negedge clk);
    len_sel = ls; stop2 = s2; par_sel = ps; q_data = d; q_empty = 1'b0;
    while (!q_pop) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    q_empty = 1'b1;
    if (drop_cts) cts = 1'b0;
    chk("R6", {req, " busy after pop"}, busy, 1'b1);
    for (int b = 0; b < nb; b++) begin
      repeat (4) wait_tick();
      chk(req, $sformatf("bit %0d", b), txd, exp_bits[b]);
      if (b < nb - 1) begin
        repeat (4) wait_tick();
      end else begin
        repeat (3) wait_tick();
        while (!tick) @(negedge clk);
        chk("R9", {req, " done pulse"}, frame_done, 1'b1);
        @(posedge clk);
        @(negedge clk);
        chk("R9", {req, " busy low after done"}, busy, 1'b0);
        chk("R5", {req, " line idle after frame"}, txd, 1'b1);
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "txd at reset", txd, 1'b1);
    chk("R1", "busy at reset", busy, 1'b0);
    chk("R1", "pop at reset", q_pop, 1'b0);
    chk("R1", "done at reset", frame_done, 1'b0);
  endtask

  task automatic t_formats();
    run_frame("R2", 8'hA5, 2'd3, 1'b0, 3'd0, 1'b0);
    run_frame("R2", 8'h3B, 2'd0, 1'b0, 3'd0, 1'b0);
    run_frame("R3", 8'h16, 2'd1, 1'b1, 3'd0, 1'b0);
    run_frame("R4", 8'h0B, 2'd0, 1'b0, 3'd4, 1'b0);
    run_frame("R4", 8'h2D, 2'd1, 1'b1, 3'd6, 1'b0);
    run_frame("R4", 8'h40, 2'd2, 1'b0, 3'd5, 1'b0);
    run_frame("R4", 8'hFF, 2'd3, 1'b1, 3'd7, 1'b0);
    run_frame("R4", 8'h81, 2'd3, 1'b0, 3'd2, 1'b0);
    run_frame("R3", 8'hC3, 2'd3, 1'b1, 3'd4, 1'b0);
  endtask

  task automatic t_flow();
    bit popped;
    @(negedge clk);
    flow_en = 1'b1; cts = 1'b0; q_data = 8'h55; q_empty = 1'b0;
    popped = 1'b0;
    repeat (60) begin
      @(negedge clk);
      if (q_pop || busy || !txd) popped = 1'b1;
    end
    chk("R7", "held off while cts low", popped, 1'b0);
    q_empty = 1'b1;
    cts = 1'b1;
    run_frame("R7", 8'h55, 2'd3, 1'b0, 3'd6, 1'b0);
    cts = 1'b1;
    run_frame("R8", 8'h9E, 2'd3, 1'b1, 3'd4, 1'b1);
    flow_en = 1'b0; cts = 1'b0;
    run_frame("R7", 8'h27, 2'd2, 1'b0, 3'd0, 1'b0);
  endtask

  task automatic t_enable();
    bit moved;
    @(negedge clk);
    port_en = 1'b0; q_data = 8'h00; q_empty = 1'b0;
    moved = 1'b0;
    repeat (60) begin
      @(negedge clk);
      if (q_pop || busy || !txd) moved = 1'b1;
    end
    chk("R10", "disabled idle", moved, 1'b0);
    port_en = 1'b1;
    while (!q_pop) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    q_empty = 1'b1;
    repeat (12) wait_tick();
    chk("R10", "data bit 0 low before abort", txd, 1'b0);
    port_en = 1'b0;
    @(negedge clk);
    chk("R10", "busy after abort", busy, 1'b0);
    chk("R10", "txd after abort", txd, 1'b1);
    port_en = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "idle after re-enable", txd, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    port_en = 1'b1;
    t_reset();
    t_formats();
    t_flow();
    t_enable();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule